// File: doc/BRIEF.md
# Word-Wide UV-Erasable ROM Behavioural Array

This block is a synthesizable stand-in for a one-time-writable, light-erasable read-only memory holding 16-bit words. Its depth is set by an address-width parameter. At full size the address is 17 bits wide, which gives 128K words. The default is kept small so that the register array stays cheap to elaborate. Control pins are active-low: a chip select, an output enable and a program strobe. Alongside them are two flags that stand for the analogue conditions on the real pins. One flag says the programming supply is raised. The other says the identifier probe voltage is present on the address line that selects identification.

From these inputs the block picks one of seven operating modes:

- standby
- program-inhibit
- program
- output-off
- program-verify
- identifier read
- normal read

Stored bits can only move from one to zero. A program cycle ANDs the incoming word into the addressed word. The only ways to return bits to one are a reset or a pulse on the whole-array erase input. Reads are combinational from the array. Writes and erases take effect on the rising clock edge. The `dataDrive` output models the difference between driving the bus and floating it. While `dataDrive` is low, `dataOut` is held at zero.

Top module: `eprom_model`

## Requirements
- R1: After reset, every word reads 16'hFFFF.
- R2: `dataDrive` is high only when both `selN` and `outEnN` are low and no program cycle is in progress. While `dataDrive` is low, `dataOut` is 16'h0000. In normal read (`hvOn` low), the addressed word is driven.
- R3: With `selN` high, `dataDrive` is low whatever the level of `outEnN`, `progN` or `idProbe`.
- R4: A program cycle needs `hvOn` high, `selN` low and `progN` low. On the clock edge it replaces the addressed word with (old AND `wdata`), so no bit ever returns from 0 to 1. During the cycle `dataDrive` is low, even if `outEnN` is low.
- R5: Program-verify needs `hvOn` high, `selN` low, `outEnN` low and `progN` high. It drives the stored word.
- R6: With `hvOn` high and `progN` low but `selN` high, the array is left unchanged (program-inhibit).
- R7: Identifier read needs `idProbe` high, `hvOn` low, `selN` and `outEnN` low, and all address bits above bit 0 at zero. Bit 0 low returns {8'h00, MFR_ID} and bit 0 high returns {8'h00, DEV_ID}. If `idProbe` is high but any higher address bit is set, the block does a normal read instead.
- R8: Both identifier bytes have odd parity over bits 7..0, with bit 7 as the parity bit; this is checked when the design is elaborated. The upper byte reads zero in identifier mode.
- R9: A program attempt with `hvOn` low leaves the array unchanged.
- R10: `eraseAll` sets every word back to 16'hFFFF on the clock edge. It takes priority over a program cycle in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and erases act on its rising edge |
| rstN | input | 1 | Active-low synchronous reset, returns array to erased state |
| eraseAll | input | 1 | Whole-array erase to all ones |
| selN | input | 1 | Active-low chip select |
| outEnN | input | 1 | Active-low output enable |
| progN | input | 1 | Active-low program strobe |
| hvOn | input | 1 | Programming supply is at its raised level |
| idProbe | input | 1 | Identifier probe voltage present |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Word to be programmed |
| dataOut | output | 16 | Read data, zero when not driven |
| dataDrive | output | 1 | High when the data bus is driven, low models high impedance |

## Verification
Some rules can be checked on every cycle, and the assertions cover those:

- the bus never drives in standby or without output enable;
- no write is ever decoded with the supply flag low or with the chip deselected;
- an addressed word never regains a one outside erase or reset;
- a word with no write stays stable;
- an erase leaves the word reading all ones;
- identifier reads always carry a zero upper byte and odd parity.

Other behaviour only shows up in the bench's scenarios:

- the cumulative AND of successive program cycles;
- the exact identifier values;
- the fall-back to a normal read when a higher address bit is set;
- the erase-over-program priority, seen across several addresses.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  localparam int WORD_W = 16;
  localparam int ID_W   = 8;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_INHIBIT,
    MD_PROGRAM,
    MD_OUTOFF,
    MD_VERIFY,
    MD_IDENT,
    MD_READ
  } modeT;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_ARRAY,
    SRC_MFR,
    SRC_DEV
  } srcT;

  typedef struct packed {
    logic wrEn;
    logic drive;
    srcT  src;
  } strobeT;

endpackage

// File: rtl/eprom_ctrl.sv
module eprom_ctrl
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              outEnN,
  input  logic              progN,
  input  logic              hvOn,
  input  logic              idProbe,
  input  logic [ADDR_W-1:0] addr,
  output strobeT            strb,
  output modeT              mode
);

  logic upperZero;

  if (ADDR_W > 1) begin : gUpper
    assign upperZero = (addr[ADDR_W-1:1] == '0);
  end else begin : gNoUpper
    assign upperZero = 1'b1;
  end

  // Mode decode, highest priority first
  always_comb begin
    if (selN) begin
      mode = (hvOn && !progN) ? MD_INHIBIT : MD_STANDBY;
    end else if (hvOn && !progN) begin
      mode = MD_PROGRAM;
    end else if (outEnN) begin
      mode = MD_OUTOFF;
    end else if (hvOn) begin
      mode = MD_VERIFY;
    end else if (idProbe && upperZero) begin
      mode = MD_IDENT;
    end else begin
      mode = MD_READ;
    end
  end

  always_comb begin
    strb = '{wrEn: 1'b0, drive: 1'b0, src: SRC_NONE};
    unique case (mode)
      MD_PROGRAM: strb.wrEn = 1'b1;
      MD_VERIFY, MD_READ: begin
        strb.drive = 1'b1;
        strb.src   = SRC_ARRAY;
      end
      MD_IDENT: begin
        strb.drive = 1'b1;
        strb.src   = addr[0] ? SRC_DEV : SRC_MFR;
      end
      default: ;
    endcase
  end

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    selN |-> !strb.drive) else $error("drive while deselected"); // R3

  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rstN)
    strb.drive |-> (!selN && !outEnN)) else $error("drive without enables"); // R2

  AST_INHIBIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    selN |-> !strb.wrEn) else $error("write while deselected"); // R6

  AST_NO_HV_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !hvOn |-> !strb.wrEn) else $error("write without supply flag"); // R9

endmodule

// File: rtl/eprom_array.sv
module eprom_array
  import eprom_pkg::*;
#(
  parameter int               ADDR_W = 6,
  parameter logic [ID_W-1:0]  MFR_ID = 8'h2A,
  parameter logic [ID_W-1:0]  DEV_ID = 8'hC4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eraseAll,
  input  strobeT            strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataDrive
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [WORD_W-ID_W-1:0] ID_PAD = '0;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] memWord;

  always_ff @(posedge clk) begin
    if (!rstN || eraseAll) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strb.wrEn) begin
      mem[addr] <= mem[addr] & wdata;
    end
  end

  assign memWord = mem[addr];

  always_comb begin
    dataDrive = strb.drive;
    unique case (strb.src)
      SRC_ARRAY: dataOut = memWord;
      SRC_MFR:   dataOut = {ID_PAD, MFR_ID};
      SRC_DEV:   dataOut = {ID_PAD, DEV_ID};
      default:   dataOut = '0;
    endcase
    if (!strb.drive) dataOut = '0;
  end

  AST_ONE_WAY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(eraseAll) && $stable(addr))
      |-> ((memWord & ~$past(memWord)) == '0)) else $error("bit returned to one"); // R4

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(eraseAll) && !$past(strb.wrEn) && $stable(addr))
      |-> $stable(memWord)) else $error("word changed without write"); // R9

  AST_ERASED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(eraseAll)) |-> (memWord == '1)) else $error("erase incomplete"); // R10

  AST_ID_FORMAT: assert property (@(posedge clk) disable iff (!rstN)
    (dataDrive && (strb.src == SRC_MFR || strb.src == SRC_DEV))
      |-> (dataOut[WORD_W-1:ID_W] == '0 && (^dataOut[ID_W-1:0]) == 1'b1))
    else $error("bad identifier word"); // R8

endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int               ADDR_W = 6,
  parameter logic [ID_W-1:0]  MFR_ID = 8'h2A,
  parameter logic [ID_W-1:0]  DEV_ID = 8'hC4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eraseAll,
  input  logic              selN,
  input  logic              outEnN,
  input  logic              progN,
  input  logic              hvOn,
  input  logic              idProbe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       dataOut,
  output logic              dataDrive
);

  strobeT strb;
  modeT   mode;

  initial begin
    AST_MFR_PARITY: assert ((^MFR_ID) == 1'b1) else $error("MFR_ID parity even"); // R8
    AST_DEV_PARITY: assert ((^DEV_ID) == 1'b1) else $error("DEV_ID parity even"); // R8
  end

  eprom_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .outEnN(outEnN), .progN(progN),
    .hvOn(hvOn), .idProbe(idProbe), .addr(addr), .strb(strb), .mode(mode)
  );

  eprom_array #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_array (
    .clk(clk), .rstN(rstN), .eraseAll(eraseAll), .strb(strb), .addr(addr),
    .wdata(wdata), .dataOut(dataOut), .dataDrive(dataDrive)
  );

  AST_PROGRAM_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && !progN && hvOn) |-> !dataDrive) else $error("drive during program"); // R4

  AST_VERIFY_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && !outEnN && progN && hvOn) |-> dataDrive) else $error("verify not driving"); // R5

endmodule

// File: tb/eprom_model_tb.sv
module eprom_model_tb;

  localparam int AW = 6;
  localparam logic [7:0] MFR = 8'h2A;
  localparam logic [7:0] DEV = 8'hC4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eraseAll = 1'b0;
  logic selN = 1'b1, outEnN = 1'b1, progN = 1'b1, hvOn = 1'b0, idProbe = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] dataOut;
  logic dataDrive;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  eprom_model #(.ADDR_W(AW), .MFR_ID(MFR), .DEV_ID(DEV)) u_dut (
    .clk(clk), .rstN(rstN), .eraseAll(eraseAll), .selN(selN), .outEnN(outEnN),
    .progN(progN), .hvOn(hvOn), .idProbe(idProbe), .addr(addr), .wdata(wdata),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

  // {req[47:44], sel, oe, prog, hv, id, addr[38:33], wdata[32:17], expDrive, expData}
  localparam int NV = 21;
  localparam logic [47:0] VEC [NV] = '{
    {4'd1,  5'b00100, 6'd5, 16'h0000, 1'b1, 16'hFFFF}, // R1 erased read
    {4'd4,  5'b01010, 6'd5, 16'hA5F0, 1'b0, 16'h0000}, // R4 program
    {4'd5,  5'b00110, 6'd5, 16'h0000, 1'b1, 16'hA5F0}, // R5 verify
    {4'd4,  5'b01010, 6'd5, 16'h0FFF, 1'b0, 16'h0000}, // R4 second pulse
    {4'd4,  5'b00110, 6'd5, 16'h0000, 1'b1, 16'h05F0}, // R4 AND result
    {4'd4,  5'b01010, 6'd5, 16'hFFFF, 1'b0, 16'h0000}, // R4 try to set ones
    {4'd4,  5'b00100, 6'd5, 16'h0000, 1'b1, 16'h05F0}, // R4 ones not restored
    {4'd9,  5'b00000, 6'd9, 16'h0000, 1'b1, 16'hFFFF}, // R9 prog without hv
    {4'd9,  5'b00100, 6'd9, 16'h0000, 1'b1, 16'hFFFF}, // R9 word kept
    {4'd6,  5'b10010, 6'd9, 16'h0000, 1'b0, 16'h0000}, // R6 inhibit
    {4'd6,  5'b00100, 6'd9, 16'h0000, 1'b1, 16'hFFFF}, // R6 word kept
    {4'd3,  5'b10100, 6'd5, 16'h0000, 1'b0, 16'h0000}, // R3 standby oe low
    {4'd3,  5'b11100, 6'd5, 16'h0000, 1'b0, 16'h0000}, // R3 standby oe high
    {4'd2,  5'b01100, 6'd5, 16'h0000, 1'b0, 16'h0000}, // R2 output off
    {4'd7,  5'b00101, 6'd0, 16'h0000, 1'b1, {8'h00, MFR}}, // R7 maker code
    {4'd7,  5'b00101, 6'd1, 16'h0000, 1'b1, {8'h00, DEV}}, // R7 device code
    {4'd7,  5'b00101, 6'd5, 16'h0000, 1'b1, 16'h05F0}, // R7 upper bit set -> read
    {4'd3,  5'b10101, 6'd0, 16'h0000, 1'b0, 16'h0000}, // R3 ident while deselected
    {4'd5,  5'b00110, 6'd9, 16'h0000, 1'b1, 16'hFFFF}, // R5 verify erased word
    {4'd4,  5'b00010, 6'd3, 16'h1234, 1'b0, 16'h0000}, // R4 program with oe low
    {4'd2,  5'b00100, 6'd3, 16'h0000, 1'b1, 16'h1234}  // R2 normal read
  };

  task automatic chk(input int req, input logic act, input logic [15:0] actD,
                     input logic exp, input logic [15:0] expD);
    nRun++;
    if (act !== exp || actD !== expD) begin
      nFail++;
      $display("FAIL R%0d: drive/data actual %b/%h expected %b/%h", req, act, actD, exp, expD);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    {selN, outEnN, progN, hvOn, idProbe} = 5'b00100;
    addr = a; eraseAll = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state on several addresses
    rd(6'd0);  chk(1, dataDrive, dataOut, 1'b1, 16'hFFFF);
    rd(6'd63); chk(1, dataDrive, dataOut, 1'b1, 16'hFFFF);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {selN, outEnN, progN, hvOn, idProbe} = VEC[i][43:39];
      addr  = VEC[i][38:33];
      wdata = VEC[i][32:17];
      @(posedge clk); #1;
      chk(int'(VEC[i][47:44]), dataDrive, dataOut, VEC[i][16], VEC[i][15:0]);
    end

    // R8 identifier parity and zero upper byte
    @(negedge clk); {selN, outEnN, progN, hvOn, idProbe} = 5'b00101; addr = 6'd0;
    #1; chk(8, 1'b0, {dataOut[15:8], 7'd0, ^dataOut[7:0]}, 1'b0, 16'h0001);
    addr = 6'd1;
    #1; chk(8, 1'b0, {dataOut[15:8], 7'd0, ^dataOut[7:0]}, 1'b0, 16'h0001);

    // R10 erase beats a simultaneous program
    @(negedge clk);
    {selN, outEnN, progN, hvOn, idProbe} = 5'b01010;
    addr = 6'd7; wdata = 16'h0000; eraseAll = 1'b1;
    @(posedge clk); #1;
    rd(6'd7); chk(10, dataDrive, dataOut, 1'b1, 16'hFFFF);
    rd(6'd5); chk(10, dataDrive, dataOut, 1'b1, 16'hFFFF);
    rd(6'd3); chk(10, dataDrive, dataOut, 1'b1, 16'hFFFF);

    // R1 reset restores erased state after programming
    @(negedge clk);
    {selN, outEnN, progN, hvOn, idProbe} = 5'b01010;
    addr = 6'd12; wdata = 16'h00FF;
    @(posedge clk); #1;
    rd(6'd12); chk(4, dataDrive, dataOut, 1'b1, 16'h00FF);
    @(negedge clk); rstN = 1'b0;
    @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    rd(6'd12); chk(1, dataDrive, dataOut, 1'b1, 16'hFFFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule